// File: doc/BRIEF.md
# Multi-Cycle Ripple Carry Adder

This block adds two 32-bit operands while spending several clock cycles on the carry chain, the way a small stack machine pays for an add over a run of instruction slots. A one-cycle `start_i` pulse captures both operands. Setup cycles then form the per-bit generate and propagate terms. After that the carry walks upward through one 8-bit segment per clock, and `valid_o` rises once the top segment has settled.

Between the start pulse and `valid_o` the outputs are not hidden. `sum_o` and `carry_o` show the live state of the chain, so a read made too early gives a sum that is missing carries. The surrounding logic must wait the fixed latency, or watch `valid_o`, before it uses the result.

The controller has four states. `ST_IDLE` is the state after reset. `ST_SETUP` forms the base terms. `ST_ADVANCE` moves the carry one segment per cycle. `ST_DONE` holds the result. The transitions are:
- IDLE to SETUP on start.
- SETUP to ADVANCE after the last setup cycle.
- ADVANCE to DONE after the top segment.
- DONE to SETUP on start.
- Any state to SETUP on start, which restarts the operation.

Top module: `mc_ripple_adder`

## Requirements
- R1: The rising clock edge that samples `start_i` high captures `a_i` and `b_i`. `valid_o` is low after that edge.
- R2: Generate is `a AND b` and propagate is `a XOR b`. Each bit's sum is `propagate XOR carry-in`. Each bit's carry-out is `generate OR (propagate AND carry-in)`.
- R3: `valid_o` is low after edges 1 to 5 that follow the start edge, and high after edge 6. This is 2 setup cycles plus 4 advance cycles.
- R4: After the first setup edge `sum_o` equals `a XOR b` and `carry_o` is 0. After the k-th advance edge (k = 1 to 3), bits [8k-1:0] of `sum_o` equal the true sum and the higher bits still equal `a XOR b`. At that point `carry_o` is the carry into bit 8k. For example, 0xFFFFFFFF + 1 reads 0xFFFFFF00 after one advance edge.
- R5: Once `valid_o` is high, `{carry_o, sum_o}` equals the 33-bit value `a + b`.
- R6: While `valid_o` is high and no start arrives, `valid_o`, `sum_o` and `carry_o` hold. Changes on `a_i` and `b_i` have no effect on them.
- R7: A start that arrives during an operation restarts it with the new operands. `valid_o` then rises 6 edges after the last start, with the new sum.
- R8: With `rst_ni` low, `valid_o`, `sum_o` and `carry_o` are all 0 after the next edge. This holds in the middle of an operation too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that captures the operands |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| sum_o | output | 32 | Live or settled sum |
| carry_o | output | 1 | Live carry, or carry out of bit 31 once valid |
| valid_o | output | 1 | Result settled |

## Verification
The assertions assume that `start_i` is sampled only on clock edges and that the operands are steady at the start edge. The checker forms its own reference from `a_i + b_i` at that edge. The ripple-window check assumes that no reset occurs during an operation it is watching.

The bench meets these assumptions. It changes every input at the falling edge. It applies a reset in mid-flight only once, and a new start follows that reset before any result is judged.

// File: rtl/mcra_pkg.sv
`timescale 1ns/1ps
package mcra_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_ADVANCE = 2'd2,
        ST_DONE    = 2'd3
    } mcra_state_e;
endpackage

// File: rtl/mcra_base.sv
`timescale 1ns/1ps
// Per-bit base terms: generate and propagate.
module mcra_base #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] gen_o,
    output logic [WIDTH-1:0] prop_o
);
    assign gen_o  = a_i & b_i;
    assign prop_o = a_i ^ b_i;
endmodule

// File: rtl/mcra_segment.sv
`timescale 1ns/1ps
// One carry segment, resolved combinationally within one clock.
module mcra_segment #(
    parameter int STEP = 8
) (
    input  logic [STEP-1:0] gen_i,
    input  logic [STEP-1:0] prop_i,
    input  logic            cin_i,
    output logic [STEP-1:0] sum_o,
    output logic            cout_o
);
    logic [STEP:0] c;

    assign c[0] = cin_i;

    for (genvar i = 0; i < STEP; i++) begin : g_bit
        assign sum_o[i] = prop_i[i] ^ c[i];
        assign c[i+1]   = gen_i[i] | (prop_i[i] & c[i]);
    end

    assign cout_o = c[STEP];
endmodule

// File: rtl/mc_ripple_adder.sv
`timescale 1ns/1ps
module mc_ripple_adder
    import mcra_pkg::*;
#(
    parameter int WIDTH        = 32,
    parameter int STEP         = 8,
    parameter int SETUP_CYCLES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             valid_o
);
    localparam int NSEG  = WIDTH / STEP;
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1;
    localparam int SET_W = (SETUP_CYCLES > 1) ? $clog2(SETUP_CYCLES) : 1;

    mcra_state_e state_q, state_d;

    logic [WIDTH-1:0] a_q, b_q, g_q, p_q, sum_q;
    logic [WIDTH-1:0] g_d, p_d;
    logic             carry_q;
    logic [SEG_W-1:0] seg_q;
    logic [SET_W-1:0] setup_q;
    logic [STEP-1:0]  seg_g, seg_p, seg_sum;
    logic             seg_cout;
    logic             last_setup, last_seg;

    mcra_base #(.WIDTH(WIDTH)) u_base (
        .a_i   (a_q),
        .b_i   (b_q),
        .gen_o (g_d),
        .prop_o(p_d)
    );

    assign seg_g = g_q[int'(seg_q)*STEP +: STEP];
    assign seg_p = p_q[int'(seg_q)*STEP +: STEP];

    mcra_segment #(.STEP(STEP)) u_seg (
        .gen_i (seg_g),
        .prop_i(seg_p),
        .cin_i (carry_q),
        .sum_o (seg_sum),
        .cout_o(seg_cout)
    );

    assign last_setup = (setup_q == SET_W'(SETUP_CYCLES - 1));
    assign last_seg   = (seg_q == SEG_W'(NSEG - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = ST_SETUP;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_SETUP:   if (last_setup) state_d = ST_ADVANCE;
                ST_ADVANCE: if (last_seg)   state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            a_q     <= '0;
            b_q     <= '0;
            g_q     <= '0;
            p_q     <= '0;
            sum_q   <= '0;
            carry_q <= 1'b0;
            seg_q   <= '0;
            setup_q <= '0;
        end else if (start_i) begin
            a_q     <= a_i;
            b_q     <= b_i;
            carry_q <= 1'b0;
            seg_q   <= '0;
            setup_q <= '0;
        end else begin
            unique case (state_q)
                ST_SETUP: begin
                    if (setup_q == '0) begin
                        g_q     <= g_d;
                        p_q     <= p_d;
                        sum_q   <= p_d;
                        carry_q <= 1'b0;
                    end
                    setup_q <= setup_q + 1'b1;
                end
                ST_ADVANCE: begin
                    sum_q[int'(seg_q)*STEP +: STEP] <= seg_sum;
                    carry_q <= seg_cout;
                    seg_q   <= seg_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sum_o   = sum_q;
        carry_o = carry_q;
        valid_o = (state_q == ST_DONE);
    end
endmodule

// File: rtl/mc_ripple_adder_chk.sv
`timescale 1ns/1ps
module mc_ripple_adder_chk #(
    parameter int WIDTH        = 32,
    parameter int STEP         = 8,
    parameter int SETUP_CYCLES = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             start_i,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             carry_o,
    input logic             valid_o
);
    localparam int LAT = SETUP_CYCLES + WIDTH / STEP;

    logic [WIDTH:0]   ref_q;
    logic [7:0]       lat_q;
    logic [WIDTH-1:0] low_mask;
    logic             in_ripple;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ref_q <= '0;
            lat_q <= 8'hFF;
        end else if (start_i) begin
            ref_q <= {1'b0, a_i} + {1'b0, b_i};
            lat_q <= 8'd0;
        end else if (lat_q != 8'hFF) begin
            lat_q <= lat_q + 8'd1;
        end
    end

    assign in_ripple = !valid_o && (int'(lat_q) > SETUP_CYCLES) && (int'(lat_q) < LAT);

    always_comb begin
        low_mask = '0;
        if (in_ripple)
            low_mask = (WIDTH'(1) << ((int'(lat_q) - SETUP_CYCLES) * STEP)) - WIDTH'(1);
    end

    assert_start_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> !valid_o);

    assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(valid_o) |-> (int'(lat_q) == LAT));

    assert_low_settled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_ripple |-> (((sum_o ^ ref_q[WIDTH-1:0]) & low_mask) == '0));

    assert_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> ({carry_o, sum_o} == ref_q));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !start_i) |=> (valid_o && $stable(sum_o) && $stable(carry_o)));
endmodule

bind mc_ripple_adder mc_ripple_adder_chk #(
    .WIDTH(WIDTH), .STEP(STEP), .SETUP_CYCLES(SETUP_CYCLES)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .sum_o  (sum_o),
    .carry_o(carry_o),
    .valid_o(valid_o)
);

// File: tb/test_mc_ripple_adder.sv
`timescale 1ns/1ps
module test_mc_ripple_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic [31:0] sum;
    logic        carry, valid;
    int          total = 0, bad = 0;
    bit          finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    mc_ripple_adder i_mc_ripple_adder (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .a_i(a), .b_i(b), .sum_o(sum), .carry_o(carry), .valid_o(valid)
    );

    localparam int NV = 8;
    localparam logic [31:0] VA [NV] = '{32'h0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h12345678,
                                        32'h80000000, 32'h00FF00FF, 32'hDEADBEEF, 32'h7FFFFFFF};
    localparam logic [31:0] VB [NV] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h87654321,
                                        32'h80000000, 32'h00010001, 32'h1, 32'h1};
    localparam logic [32:0] VS [NV] = '{33'h0, 33'h100000000, 33'h1FFFFFFFE, 33'h099999999,
                                        33'h100000000, 33'h001000100, 33'h0DEADBEF0, 33'h080000000};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_start(input logic [31:0] x, input logic [31:0] y);
        a = x; b = y; start = 1'b1;
        tick();
        start = 1'b0;
        chk(valid == 1'b0, "R1 valid after start", 64'(valid), 64'd0);
    endtask

    // Expected live state after k advance edges (k=0 means only setup done).
    task automatic chk_stage(input logic [31:0] x, input logic [31:0] y, input int k);
        logic [63:0] mask, full, es, ec;
        mask = (k == 0) ? 64'd0 : ((64'd1 << (8*k)) - 64'd1);
        full = {32'd0, x} + {32'd0, y};
        es   = (full & mask) | ({32'd0, x ^ y} & ~mask);
        ec   = ((({32'd0, x} & mask) + ({32'd0, y} & mask)) >> (8*k)) & 64'd1;
        chk(sum == es[31:0], "R4 partial sum", 64'(sum), {32'd0, es[31:0]});
        chk(carry == ec[0], "R4 partial carry", 64'(carry), ec);
    endtask

    // Full run with per-edge checks of latency, live state and result.
    task automatic run_op(input logic [31:0] x, input logic [31:0] y, input logic [32:0] exp);
        pulse_start(x, y);
        for (int e = 1; e <= 6; e++) begin
            tick();
            chk(valid == (e == 6), "R3 valid timing", 64'(valid), 64'(e == 6));
            if (e < 6) chk_stage(x, y, (e <= 2) ? 0 : e - 2);
        end
        chk({carry, sum} == exp, "R5 final result", 64'({carry, sum}), 64'(exp));
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] hs;
        logic        hc;
        logic [31:0] rx, ry;

        // R8: reset state
        tick(); tick();
        chk(valid == 0 && sum == 0 && carry == 0, "R8 reset state",
            64'({valid, carry, sum}), 64'd0);
        rst_n = 1'b1;
        tick();

        // Vector table (R2 exercised by every sum and carry)
        for (int i = 0; i < NV; i++) run_op(VA[i], VB[i], VS[i]);

        // R4: early read of a long carry is visibly wrong
        pulse_start(32'hFFFFFFFF, 32'h1);
        tick(); tick(); tick();
        chk(sum == 32'hFFFFFF00, "R4 early read value", 64'(sum), 64'hFFFFFF00);
        chk(sum != 32'h0, "R4 early read differs from true sum", 64'(sum), 64'h0);
        tick(); tick(); tick();

        // R6: hold while valid, operand changes ignored
        hs = sum; hc = carry;
        a = 32'h55555555; b = 32'hAAAAAAAB;
        for (int i = 0; i < 5; i++) tick();
        chk(valid == 1 && sum == hs && carry == hc, "R6 hold",
            64'({valid, carry, sum}), 64'({1'b1, hc, hs}));

        // R7: restart during advance phase
        pulse_start(32'h0F0F0F0F, 32'h11111111);
        tick(); tick(); tick();
        pulse_start(32'hFFFF0000, 32'h00010000);
        for (int e = 1; e <= 6; e++) begin
            tick();
            chk(valid == (e == 6), "R7 restart timing", 64'(valid), 64'(e == 6));
        end
        chk({carry, sum} == 33'h100000000, "R7 restart result",
            64'({carry, sum}), 64'h100000000);

        // Random operands (R5)
        for (int i = 0; i < 20; i++) begin
            rx = $urandom; ry = $urandom;
            run_op(rx, ry, {1'b0, rx} + {1'b0, ry});
        end

        // R8: reset mid-operation
        pulse_start(32'hFFFFFFFF, 32'hFFFFFFFF);
        tick(); tick(); tick();
        rst_n = 1'b0;
        tick();
        chk(valid == 0 && sum == 0 && carry == 0, "R8 reset mid-op",
            64'({valid, carry, sum}), 64'd0);
        rst_n = 1'b1;
        tick();
        run_op(32'h00000001, 32'h00000002, 33'h3);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule